// File: doc/BRIEF.md
# Periodic Down-Count Tick Timer

This block is a periodic tick source with four 32-bit word registers on a simple synchronous register bus. A 24-bit counter runs down to zero. On the next counting step it reloads from a programmable reload register, so zero marks the end of every period. Each time the count arrives at zero, a sticky flag is set. If the interrupt enable is on, a one-clock tick request is also raised.

The flag is cleared by reading the control/status word. Writing any value to the current-count register zeroes both the count and the flag, and this write never raises a tick.

A counting step can come from one of two sources. One source steps on every clock. The other steps only on clocks where an external reference-tick enable is high. A debug-halt input freezes the count. Read data is combinational: it returns the register contents in the cycle of the access, and any side effect of the access takes place at the closing clock edge.

Top module: `tick_timer`

## Requirements
- R1: After synchronous reset, the control/status word, the reload register and the current count all read 0. The calibration word at offset 0x1C reads 0xC0000000.
- R2: Byte offsets 0x10, 0x14, 0x18 and 0x1C decode to control/status, reload, current count and calibration. Any other offset, and any offset with address bits 1:0 not zero, reads 0 and has no effect.
- R3: While enabled (control bit 0), each counting step lowers a nonzero count by one. A step taken at count 0 loads the reload value.
- R4: Control bit 2 set to 1 makes every clock a counting step. With bit 2 at 0, only clocks with the reference-tick input high are steps.
- R5: A reload value of 0 leaves the counter at 0 after its next wrap, and the counter then stays there.
- R6: The count flag (control/status bit 16) becomes 1 when a step moves the count from 1 to 0.
- R7: A read of control/status returns the flag and then clears it. If a 1-to-0 step happens on the same clock as that read, the flag stays 1.
- R8: A write of any data to the current-count register sets the count and the flag to 0 on that edge, overrides any step on the same clock, and raises no tick.
- R9: The tick request is high for exactly one clock: the first clock in which the count reads 0 after a 1-to-0 step, provided control bit 1 was set when the step happened. It is low at all other times.
- R10: While debug-halt is high, the count does not change, except through a current-count write.
- R11: The reload and current-count registers hold 24 bits. Bits 31:24 read 0 and ignore writes. In control/status, bits 31:17 and 15:3 read 0, and the flag bit cannot be written.
- R12: A read of the current-count register returns the count as it stands in that cycle, before that clock's step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe, one transfer per clock |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset within the page |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| ref_tick | input | 1 | External reference step enable |
| dbg_halt | input | 1 | Freezes counting while high |
| tick_irq | output | 1 | One-clock tick request |

## Verification
The bench checks three cases that share one clock edge. The first is a status read on the clock of a 1-to-0 step: a design that lets the clear win loses the event. The second is a current-count write while counting: a wrong design steps anyway or raises a spurious tick. The third is a zero reload: a wrong design either keeps producing ticks or wraps to all ones. Misaligned and unmapped accesses are mixed into the random traffic. A decoder that ignores the low address bits would then corrupt the reload value. Halt and the reference-tick enable are toggled at random against a cycle model, which catches a counter that steps while frozen or ignores the source select.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

    localparam int DATA_W   = 32;
    localparam int CNT_W    = 24;
    localparam int ADDR_W   = 12;
    localparam int FLAG_BIT = 16;

    localparam logic [ADDR_W-1:0] OFS_CSR = 12'h010;
    localparam logic [ADDR_W-1:0] OFS_RVR = 12'h014;
    localparam logic [ADDR_W-1:0] OFS_CVR = 12'h018;
    localparam logic [ADDR_W-1:0] OFS_CAL = 12'h01C;

    localparam logic [DATA_W-1:0] CAL_WORD = 32'hC000_0000;

    typedef enum logic [2:0] {
        RS_NONE,
        RS_CSR,
        RS_RVR,
        RS_CVR,
        RS_CAL
    } reg_sel_e;

    typedef struct packed {
        logic src_core;
        logic irq_en;
        logic run;
    } ctrl_t;

    typedef struct packed {
        logic csr_rd;
        logic cvr_wr;
    } side_t;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        if (a[1:0] != 2'b00) begin
            s = RS_NONE;
        end else begin
            case (a)
                OFS_CSR: s = RS_CSR;
                OFS_RVR: s = RS_RVR;
                OFS_CVR: s = RS_CVR;
                OFS_CAL: s = RS_CAL;
                default: s = RS_NONE;
            endcase
        end
        return s;
    endfunction

    function automatic logic [DATA_W-1:0] pack_csr(input ctrl_t c, input logic flag);
        logic [DATA_W-1:0] w;
        w           = '0;
        w[0]        = c.run;
        w[1]        = c.irq_en;
        w[2]        = c.src_core;
        w[FLAG_BIT] = flag;
        return w;
    endfunction

    function automatic logic [DATA_W-1:0] zext_cnt(input logic [CNT_W-1:0] v);
        return {{(DATA_W-CNT_W){1'b0}}, v};
    endfunction

endpackage

// File: rtl/tick_regbus.sv
module tick_regbus
    import tick_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [CNT_W-1:0]  cur_cnt,
    input  logic              cnt_flag,
    output ctrl_t             ctrl,
    output logic [CNT_W-1:0]  reload,
    output side_t             side,
    output logic [DATA_W-1:0] bus_rdata
);

    reg_sel_e sel;
    logic     wr_en;
    logic     rd_en;
    logic     unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:CNT_W];

    assign sel   = bus_sel ? decode_addr(bus_addr) : RS_NONE;
    assign wr_en = bus_sel && bus_wr;
    assign rd_en = bus_sel && !bus_wr;

    assign side.csr_rd = rd_en && (sel == RS_CSR);
    assign side.cvr_wr = wr_en && (sel == RS_CVR);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl   <= '0;
            reload <= '0;
        end else if (wr_en) begin
            if (sel == RS_CSR) begin
                ctrl.run      <= bus_wdata[0];
                ctrl.irq_en   <= bus_wdata[1];
                ctrl.src_core <= bus_wdata[2];
            end
            if (sel == RS_RVR) begin
                reload <= bus_wdata[CNT_W-1:0];
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (rd_en) begin
            case (sel)
                RS_CSR:  bus_rdata = pack_csr(ctrl, cnt_flag);
                RS_RVR:  bus_rdata = zext_cnt(reload);
                RS_CVR:  bus_rdata = zext_cnt(cur_cnt);
                RS_CAL:  bus_rdata = CAL_WORD;
                default: bus_rdata = '0;
            endcase
        end
    end

    AST_RVR_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && bus_addr == OFS_RVR) |=> (reload == $past(bus_wdata[CNT_W-1:0]))); // R11

    AST_MISALIGNED_NOP: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_addr[1:0] != 2'b00) |=> ($stable(ctrl) && $stable(reload))); // R2

    AST_WRITE_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (bus_rdata == '0)); // R2

endmodule

// File: rtl/tick_counter.sv
module tick_counter
    import tick_timer_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  ctrl_t            ctrl,
    input  logic             ref_tick,
    input  logic             dbg_halt,
    input  logic [CNT_W-1:0] reload,
    input  side_t            side,
    output logic [CNT_W-1:0] cur_cnt,
    output logic             cnt_flag,
    output logic             tick_irq
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic             step;
    logic             zero_evt;
    logic [CNT_W-1:0] cur_nxt;

    assign step = ctrl.run && !dbg_halt && (ctrl.src_core || ref_tick);

    always_comb begin
        cur_nxt  = cur_cnt;
        zero_evt = 1'b0;
        if (side.cvr_wr) begin
            cur_nxt = '0;
        end else if (step) begin
            if (cur_cnt == '0) begin
                cur_nxt = reload;
            end else begin
                cur_nxt  = cur_cnt - ONE;
                zero_evt = (cur_cnt == ONE);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_cnt  <= '0;
            cnt_flag <= 1'b0;
            tick_irq <= 1'b0;
        end else begin
            cur_cnt  <= cur_nxt;
            cnt_flag <= zero_evt || (cnt_flag && !side.csr_rd && !side.cvr_wr);
            tick_irq <= zero_evt && ctrl.irq_en;
        end
    end

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
        tick_irq |=> !tick_irq); // R9

    AST_IRQ_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        tick_irq |-> (cur_cnt == '0 && cnt_flag)); // R6

    AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (dbg_halt && !side.cvr_wr) |=> (cur_cnt == $past(cur_cnt))); // R10

    AST_CVR_CLEAR: assert property (@(posedge clk) disable iff (rst)
        side.cvr_wr |=> (cur_cnt == '0 && !cnt_flag && !tick_irq)); // R8

    AST_ZERO_RELOAD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cur_cnt == '0 && reload == '0) |=> (cur_cnt == '0)); // R5

    AST_FLAG_BEATS_READ: assert property (@(posedge clk) disable iff (rst)
        (step && cur_cnt == ONE && !side.cvr_wr) |=> (cnt_flag && cur_cnt == '0)); // R7

endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tick_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ref_tick,
    input  logic              dbg_halt,
    output logic              tick_irq
);

    ctrl_t            ctrl;
    side_t            side;
    logic [CNT_W-1:0] reload;
    logic [CNT_W-1:0] cur_cnt;
    logic             cnt_flag;

    tick_regbus u_regbus (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .cur_cnt   (cur_cnt),
        .cnt_flag  (cnt_flag),
        .ctrl      (ctrl),
        .reload    (reload),
        .side      (side),
        .bus_rdata (bus_rdata)
    );

    tick_counter u_counter (
        .clk      (clk),
        .rst      (rst),
        .ctrl     (ctrl),
        .ref_tick (ref_tick),
        .dbg_halt (dbg_halt),
        .reload   (reload),
        .side     (side),
        .cur_cnt  (cur_cnt),
        .cnt_flag (cnt_flag),
        .tick_irq (tick_irq)
    );

    AST_CAL_CONST: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_wr && bus_addr == OFS_CAL) |-> (bus_rdata == CAL_WORD)); // R1

endmodule

// File: tb/tick_timer_test.sv
module tick_timer_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_sel;
    logic        bus_wr;
    logic [11:0] bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        ref_tick;
    logic        dbg_halt;
    logic        tick_irq;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit done  = 0;

    bit [2:0]  m_ctrl;
    bit [23:0] m_rvr;
    bit [23:0] m_cur;
    bit        m_flag;
    bit        m_irq;

    always #5 clk = ~clk;

    tick_timer uut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ref_tick(ref_tick), .dbg_halt(dbg_halt), .tick_irq(tick_irq)
    );

    function automatic int reg_of(input logic [11:0] a);
        if (a[1:0] != 2'b00) return 0;
        case (a)
            12'h010: return 1;
            12'h014: return 2;
            12'h018: return 3;
            12'h01C: return 4;
            default: return 0;
        endcase
    endfunction

    function automatic logic [31:0] model_read(input logic [11:0] a);
        case (reg_of(a))
            1:       return {15'd0, m_flag, 13'd0, m_ctrl};
            2:       return {8'd0, m_rvr};
            3:       return {8'd0, m_cur};
            4:       return 32'hC000_0000;
            default: return 32'd0;
        endcase
    endfunction

    function automatic string tag_of(input logic [11:0] a);
        case (reg_of(a))
            1:       return "R7";
            2:       return "R11";
            3:       return "R12";
            4:       return "R1";
            default: return "R2";
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic op(input bit s, input bit w, input logic [11:0] a, input logic [31:0] d,
                      input bit h, input bit rt, input string tag);
        bit        step, zero, csr_rd, cvr_wr;
        bit [23:0] ncur;
        bit        nflag;
        int        r;
        @(negedge clk);
        bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d;
        dbg_halt = h; ref_tick = rt;
        #1;
        if (s && !w) check(bus_rdata == model_read(a), tag, bus_rdata, model_read(a));
        r      = s ? reg_of(a) : 0;
        csr_rd = s && !w && r == 1;
        cvr_wr = s && w && r == 3;
        step   = m_ctrl[0] && !h && (m_ctrl[2] || rt);
        zero   = 0;
        ncur   = m_cur;
        if (cvr_wr) ncur = 0;
        else if (step) begin
            if (m_cur == 0) ncur = m_rvr;
            else begin
                ncur = m_cur - 24'd1;
                zero = (m_cur == 24'd1);
            end
        end
        nflag = zero || (m_flag && !csr_rd && !cvr_wr);
        @(posedge clk);
        #1;
        m_irq  = zero && m_ctrl[1];
        m_cur  = ncur;
        m_flag = nflag;
        if (s && w && r == 1) m_ctrl = d[2:0];
        if (s && w && r == 2) m_rvr = d[23:0];
        check(tick_irq == m_irq, "R9", {31'd0, tick_irq}, {31'd0, m_irq});
    endtask

    task automatic rd(input logic [11:0] a, input string tag);
        op(1, 0, a, 32'd0, 0, 0, tag);
    endtask

    task automatic wrr(input logic [11:0] a, input logic [31:0] d);
        op(1, 1, a, d, 0, 0, "R2");
    endtask

    task automatic idle(input int n, input bit h, input bit rt);
        for (int i = 0; i < n; i++) op(0, 0, 12'h0, 32'd0, h, rt, "R3");
    endtask

    initial begin : watchdog
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000 && !done) begin
                bad++;
                total++;
                $display("FAIL watchdog: actual=%0d expected<150000 cycles", cyc);
                $display("  test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin : stim
        logic [11:0] addrs [8];
        addrs[0] = 12'h010; addrs[1] = 12'h014; addrs[2] = 12'h018; addrs[3] = 12'h01C;
        addrs[4] = 12'h011; addrs[5] = 12'h016; addrs[6] = 12'h020; addrs[7] = 12'h000;
        void'($urandom(32'd1234));
        rst = 1; bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
        ref_tick = 0; dbg_halt = 0;
        m_ctrl = 0; m_rvr = 0; m_cur = 0; m_flag = 0; m_irq = 0;
        repeat (4) @(posedge clk);
        @(negedge clk); rst = 0;

        // R1 reset contents
        rd(12'h010, "R1"); rd(12'h014, "R1"); rd(12'h018, "R1"); rd(12'h01C, "R1");

        // R11 upper bits and unwritable flag
        wrr(12'h014, 32'hFFFF_FFFF); rd(12'h014, "R11");
        wrr(12'h010, 32'hFFFF_FFF8); rd(12'h010, "R11");

        // R2 misaligned / unmapped accesses
        wrr(12'h015, 32'h0000_0005); wrr(12'h024, 32'h1); rd(12'h014, "R2");
        rd(12'h017, "R2"); rd(12'h030, "R2");

        // R3 R6 R9 core clock counting with tick enabled
        wrr(12'h014, 32'd3); wrr(12'h010, 32'h7);
        for (int i = 0; i < 10; i++) rd(12'h018, "R3");
        rd(12'h010, "R6"); rd(12'h010, "R7");

        // R7 status read on the same clock as a 1-to-0 step
        while (m_cur != 24'd1) idle(1, 0, 0);
        rd(12'h010, "R7"); rd(12'h010, "R7"); rd(12'h010, "R7");

        // R8 current-count write while counting
        idle(1, 0, 0);
        while (m_cur != 24'd1) idle(1, 0, 0);
        wrr(12'h018, 32'hDEAD_BEEF); rd(12'h018, "R8"); rd(12'h010, "R8");

        // R10 halt freezes
        idle(2, 0, 0);
        idle(6, 1, 1); rd(12'h018, "R10");

        // R4 reference source
        wrr(12'h010, 32'h3);
        idle(5, 0, 0); rd(12'h018, "R4");
        idle(3, 0, 1); rd(12'h018, "R4");

        // R5 zero reload stops after wrap
        wrr(12'h010, 32'h7); wrr(12'h014, 32'd0);
        idle(8, 0, 0); rd(12'h018, "R5"); idle(3, 0, 0); rd(12'h018, "R5");

        // R12 read while running
        wrr(12'h014, 32'd20); wrr(12'h018, 32'd0); idle(4, 0, 0);
        rd(12'h018, "R12"); rd(12'h018, "R12");

        // random traffic
        for (int n = 0; n < 4000; n++) begin
            int unsigned kind;
            logic [11:0] a;
            logic [31:0] d;
            kind = $urandom % 8;
            a    = addrs[$urandom % 8];
            d    = $urandom;
            if (a == 12'h014 && ($urandom % 4) != 0) d = $urandom % 6;
            if (a == 12'h010 && ($urandom % 3) != 0) d = {$urandom, 3'b001} | 32'h1;
            if (kind < 3)
                op(0, 0, 12'h0, 32'd0, ($urandom % 8) == 0, $urandom % 2, "R3");
            else if (kind < 6)
                op(1, 0, a, 32'd0, ($urandom % 8) == 0, $urandom % 2, tag_of(a));
            else if (a != 12'h018 || ($urandom % 4) == 0)
                op(1, 1, a, d, ($urandom % 8) == 0, $urandom % 2, "R2");
            else
                op(0, 0, 12'h0, 32'd0, 0, $urandom % 2, "R4");
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule